// File: doc/BRIEF.md
# Multi-Target SPI Command Master

This block drives one shared serial clock and data pair towards several peripheral devices, each selected by its own active-low select line. Software-side logic hands it a command (target index and byte count) and then feeds the outgoing bytes one at a time through a ready/valid stream. The block asserts the chosen select, shifts the bytes out most significant bit first, and releases the select once the last bit has left. It then pulses a completion flag. Each target has its own upper limit on frame length. One wide target accepts up to 21 bytes, and all others accept up to 5.

The upper targets are option boards, which can also return data. For these, the bits captured on the return line come back as a byte stream. An option board asks for service by raising its interrupt input. When the block is idle it answers on its own. It selects that board, clocks a fixed-length read while sending zero bytes, and returns the captured bytes. Pending interrupts are taken in fixed order, lowest option index first, and they win over a waiting command.

Top module: `spim_master`

## Requirements
- R1: Out of reset every `csn_o` bit is 1. During a transaction exactly one bit is 0: the one with the addressed device index. It stays 0, unchanged, from the cycle after acceptance until release.
- R2: `sclk_o` is 0 whenever no select is asserted. Over a transaction it makes exactly 8 rising edges per byte transferred and no others.
- R3: After the final falling edge, `sclk_o` stays low for HALF_CYC cycles. In the next cycle every select is 1, `busy_o` is 0, and `done_o` is 1 for one cycle while `act_dev_o` still shows the finished device.
- R4: Bytes leave on `mosi_o` most significant bit first. `mosi_o` changes only while `sclk_o` is 0 and stays stable through each high phase. Each high phase lasts HALF_CYC cycles.
- R5: The byte count is taken from `cmd_len_i` with two adjustments. A count of 0 becomes 1. A count above the target's limit is cut to that limit: WIDE_MAX (21) for device WIDE_DEV (0), and NARROW_MAX (5) for every other device.
- R6: `miso_i` is sampled on each rising edge, most significant bit first. A completed byte appears on `rx_data_o` with a one-cycle `rx_valid_o` only when the device is an option target (index NUM_DEV-NUM_OPT and above, that is 4 and 5). Write-only devices produce no `rx_valid_o`.
- R7: `busy_o` is 1 from acceptance until release. `cmd_ready_o` is 1 only while idle with no interrupt pending, and a command is taken only in a cycle where `cmd_valid_i` and `cmd_ready_o` are both 1.
- R8: When idle, a set bit `irq_i[k]` starts a read of IRQ_RD_BYTES (3) bytes on device NUM_DEV-NUM_OPT+k. During that read `mosi_o` carries 0x00 and `tx_ready_o` stays 0.
- R9: With several interrupts pending, the lowest k is served first. A pending interrupt is served before a command that waits at the same time.
- R10: Each command byte is requested with `tx_ready_o` and taken when `tx_valid_i` is 1. While the byte is withheld, `sclk_o` stays low, the select stays asserted and no edges occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Command can be taken this cycle |
| cmd_dev_i | input | 3 | Target device index |
| cmd_len_i | input | 5 | Requested byte count |
| tx_valid_i | input | 1 | Outgoing byte present |
| tx_ready_o | output | 1 | Block wants the next outgoing byte |
| tx_data_i | input | 8 | Outgoing byte |
| rx_valid_o | output | 1 | Returned byte strobe |
| rx_data_o | output | 8 | Returned byte |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Transaction in progress |
| act_dev_o | output | 3 | Device of the current or last transaction |
| irq_i | input | 2 | Option service requests, level sensitive |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to devices |
| miso_i | input | 1 | Serial data from devices |
| csn_o | output | 6 | Active-low selects, one per device |

## Verification
The assertions assume two things about the inputs. `cmd_dev_i` names an existing device, and an option board drops its interrupt once its select goes low, so it is not served twice. The assertions also rely on `miso_i` changing only while the clock is low. The bench model respects all of this. Its device model changes the return line only at a select fall or a clock fall. It clears each interrupt bit the first time it sees that option's select asserted. It issues only valid device indices, and it drives commands and bytes half a period away from the active edge.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_LOW,
    ST_HIGH,
    ST_TAIL
  } spim_state_e;

  // zero means one byte, anything above the device limit is cut to it
  function automatic int unsigned spim_eff_len(int unsigned req, int unsigned lim);
    if (req == 0) return 1;
    if (req > lim) return lim;
    return req;
  endfunction

endpackage

// File: rtl/spim_prio.sv
module spim_prio #(
  parameter int N  = 2,
  parameter int IW = 1
) (
  input  logic [N-1:0]  req_i,
  output logic          gnt_valid_o,
  output logic [IW-1:0] gnt_idx_o
);

  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = IW'(i);
      end
    end
  end

  always_comb begin
    if (gnt_valid_o) begin
      // R9: granted request is set and nothing below it is
      a_r9_lowest_wins: assert (req_i[gnt_idx_o] &&
                                ((req_i & ((N'(1) << gnt_idx_o) - N'(1))) == '0));
    end
  end

endmodule

// File: rtl/spim_tick.sv
module spim_tick #(
  parameter int HALF_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic end_o
);

  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [CW-1:0] cnt_q;

  assign end_o = run_i && (cnt_q == CW'(HALF_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || end_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + CW'(1);
  end

  // R4: phase counter never runs past one half period
  a_r4_phase_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) < HALF_CYC);

endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [BW-1:0] load_data_i,
  input  logic          sample_i,
  input  logic          shift_i,
  input  logic          miso_i,
  output logic          mosi_o,
  output logic [BW-1:0] rx_byte_o,
  output logic          last_bit_o
);

  localparam int CW = $clog2(BW);

  logic [BW-1:0] tx_q, rx_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      tx_q  <= load_data_i;
      cnt_q <= '0;
    end else if (shift_i) begin
      tx_q  <= {tx_q[BW-2:0], 1'b0};
      cnt_q <= cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_q <= '0;
    else if (sample_i) rx_q <= {rx_q[BW-2:0], miso_i};
  end

  assign mosi_o     = tx_q[BW-1];
  assign rx_byte_o  = rx_q;
  assign last_bit_o = (cnt_q == CW'(BW - 1));

  // R4: a shift never follows the final bit of a byte without a reload
  a_r4_no_overshift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> !last_bit_o);

endmodule

// File: rtl/spim_master.sv
module spim_master
  import spim_pkg::*;
#(
  parameter int NUM_DEV      = 6,
  parameter int NUM_OPT      = 2,
  parameter int WIDE_DEV     = 0,
  parameter int WIDE_MAX     = 21,
  parameter int NARROW_MAX   = 5,
  parameter int IRQ_RD_BYTES = 3,
  parameter int HALF_CYC     = 2,
  localparam int DEV_W       = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int LEN_W       = $clog2(WIDE_MAX + 1),
  localparam int OPT_W       = (NUM_OPT > 1) ? $clog2(NUM_OPT) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  input  logic [DEV_W-1:0]   cmd_dev_i,
  input  logic [LEN_W-1:0]   cmd_len_i,
  input  logic               tx_valid_i,
  output logic               tx_ready_o,
  input  logic [7:0]         tx_data_i,
  output logic               rx_valid_o,
  output logic [7:0]         rx_data_o,
  output logic               done_o,
  output logic               busy_o,
  output logic [DEV_W-1:0]   act_dev_o,
  input  logic [NUM_OPT-1:0] irq_i,
  output logic               sclk_o,
  output logic               mosi_o,
  input  logic               miso_i,
  output logic [NUM_DEV-1:0] csn_o
);

  localparam int OPT_BASE = NUM_DEV - NUM_OPT;

  spim_state_e      state_q;
  logic [DEV_W-1:0] dev_q;
  logic [LEN_W-1:0] left_q;
  logic             rd_q, from_cmd_q;
  logic             done_q, rx_valid_q;
  logic [7:0]       rx_data_q;

  logic             irq_any;
  logic [OPT_W-1:0] irq_idx;
  logic             phase_run, phase_end;
  logic             load, sample, shift, byte_end, last_bit;
  logic [7:0]       rx_byte;
  logic             idle;
  int unsigned      lim;
  logic [LEN_W-1:0] eff_len;

  spim_prio #(.N(NUM_OPT), .IW(OPT_W)) u_prio (
    .req_i       (irq_i),
    .gnt_valid_o (irq_any),
    .gnt_idx_o   (irq_idx)
  );

  spim_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (phase_run),
    .end_o  (phase_end)
  );

  spim_shift #(.BW(8)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_data_i (from_cmd_q ? tx_data_i : 8'h00),
    .sample_i    (sample),
    .shift_i     (shift),
    .miso_i      (miso_i),
    .mosi_o      (mosi_o),
    .rx_byte_o   (rx_byte),
    .last_bit_o  (last_bit)
  );

  assign idle        = (state_q == ST_IDLE);
  assign cmd_ready_o = idle && !irq_any;
  assign tx_ready_o  = (state_q == ST_LOAD) && from_cmd_q;
  assign load        = (state_q == ST_LOAD) && (!from_cmd_q || tx_valid_i);
  assign phase_run   = (state_q == ST_LOW) || (state_q == ST_HIGH) || (state_q == ST_TAIL);
  assign sample      = (state_q == ST_LOW) && phase_end;
  assign shift       = (state_q == ST_HIGH) && phase_end && !last_bit;
  assign byte_end    = (state_q == ST_HIGH) && phase_end && last_bit;

  assign lim     = (32'(cmd_dev_i) == WIDE_DEV) ? WIDE_MAX : NARROW_MAX;
  assign eff_len = LEN_W'(spim_eff_len(32'(cmd_len_i), lim));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      dev_q      <= '0;
      left_q     <= '0;
      rd_q       <= 1'b0;
      from_cmd_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (irq_any) begin
            dev_q      <= DEV_W'(OPT_BASE) + DEV_W'(irq_idx);
            left_q     <= LEN_W'(IRQ_RD_BYTES);
            rd_q       <= 1'b1;
            from_cmd_q <= 1'b0;
            state_q    <= ST_LOAD;
          end else if (cmd_valid_i) begin
            dev_q      <= cmd_dev_i;
            left_q     <= eff_len;
            rd_q       <= (32'(cmd_dev_i) >= OPT_BASE);
            from_cmd_q <= 1'b1;
            state_q    <= ST_LOAD;
          end
        end
        ST_LOAD: if (load) state_q <= ST_LOW;
        ST_LOW:  if (phase_end) state_q <= ST_HIGH;
        ST_HIGH: begin
          if (phase_end) begin
            if (last_bit) begin
              left_q  <= left_q - LEN_W'(1);
              state_q <= (left_q == LEN_W'(1)) ? ST_TAIL : ST_LOAD;
            end else begin
              state_q <= ST_LOW;
            end
          end
        end
        ST_TAIL: if (phase_end) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q     <= 1'b0;
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
    end else begin
      done_q     <= (state_q == ST_TAIL) && phase_end;
      rx_valid_q <= byte_end && rd_q;
      if (byte_end && rd_q) rx_data_q <= rx_byte;
    end
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_csn
    assign csn_o[g] = !(!idle && (dev_q == DEV_W'(g)));
  end

  assign sclk_o     = (state_q == ST_HIGH);
  assign busy_o     = !idle;
  assign act_dev_o  = dev_q;
  assign done_o     = done_q;
  assign rx_valid_o = rx_valid_q;
  assign rx_data_o  = rx_data_q;

  // R1: never more than one device selected
  a_r1_cs_onecold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~csn_o));

  // R1: select pattern frozen for the whole transaction
  a_r1_cs_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(csn_o));

  // R2: clock idles low with no select active
  a_r2_sclk_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&csn_o) |-> !sclk_o);

  // R3: completion coincides with release
  a_r3_done_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((&csn_o) && !busy_o));

  // R4: data line holds through each high phase
  a_r4_mosi_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  // R6: returned bytes only from option targets
  a_r6_rx_opt_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> (32'(act_dev_o) >= OPT_BASE));

  // R7: no command accepted while busy
  a_r7_no_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !cmd_ready_o);

  // R10: withheld byte keeps the clock parked low
  a_r10_stall_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_ready_o && !tx_valid_i) |=> !sclk_o);

endmodule

// File: tb/test_spim_master.sv
module test_spim_master;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_DEV    = 6;
  localparam int NUM_OPT    = 2;
  localparam int OPT_BASE   = NUM_DEV - NUM_OPT;
  localparam int WIDE_MAX   = 21;
  localparam int NARROW_MAX = 5;
  localparam int IRQ_RD     = 3;
  localparam int HALF       = 2;

  logic       clk, rst_n;
  logic       cmd_valid, cmd_ready;
  logic [2:0] cmd_dev;
  logic [4:0] cmd_len;
  logic       tx_valid, tx_ready;
  logic [7:0] tx_data;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       done, busy;
  logic [2:0] act_dev;
  logic [1:0] irq;
  logic       sclk, mosi, miso;
  logic [5:0] csn;

  spim_master i_spim_master (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_dev_i(cmd_dev), .cmd_len_i(cmd_len),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_data_i(tx_data),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .done_o(done), .busy_o(busy), .act_dev_o(act_dev),
    .irq_i(irq), .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .csn_o(csn)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [11:0] exp_mosi[$];
  logic [7:0]  exp_rx[$];
  int          exp_done[$];

  int byte_cnt = 0, rises = 0, rx_seen = 0, txr_cnt = 0, hi_run = 0, bad_phase = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int dev, input int idx);
    return 8'h5A ^ 8'(dev * 16 + idx);
  endfunction

  function automatic logic [7:0] txb(input int dev, input int idx);
    return 8'h3C + 8'(idx * 7) + 8'(dev);
  endfunction

  function automatic int eff_len(input int dev, input int len);
    int lim;
    lim = (dev == 0) ? WIDE_MAX : NARROW_MAX;
    if (len == 0) return 1;
    return (len > lim) ? lim : len;
  endfunction

  function automatic int low_dev();
    for (int i = 0; i < NUM_DEV; i++) if (!csn[i]) return i;
    return 0;
  endfunction

  // device model: drive return line at select fall and at each clock fall
  logic sel, sel_seen;
  int   s_bit, s_idx, cur_dev;
  assign sel = (csn != '1);
  initial begin sel_seen = 1'b0; miso = 1'b0; end
  always @(posedge sel, negedge sel, negedge sclk) begin
    logic [7:0] t;
    if (!sel) sel_seen = 1'b0;
    else if (!sel_seen) begin
      sel_seen = 1'b1; cur_dev = low_dev(); s_bit = 0; s_idx = 0;
      t = pat(cur_dev, 0); miso = t[7];
    end else begin
      s_bit++;
      if (s_bit == 8) begin s_bit = 0; s_idx++; end
      t = pat(cur_dev, s_idx); miso = t[7 - s_bit];
    end
  end

  // scoreboard monitor for outgoing bytes
  int m_bit = 0;
  logic [7:0] m_sh;
  always @(posedge sclk) begin
    logic [11:0] e;
    rises++;
    m_sh = {m_sh[6:0], mosi};
    m_bit++;
    if (m_bit == 8) begin
      m_bit = 0;
      byte_cnt++;
      chk($countones(~csn) == 1, "R1 single select", 32'(~csn), 1);
      if (exp_mosi.size() == 0) chk(0, "R4 unexpected byte", m_sh, 0);
      else begin
        e = exp_mosi.pop_front();
        chk(low_dev() == int'(e[11:8]), "R1 selected device", low_dev(), e[11:8]);
        chk(m_sh == e[7:0], "R4 mosi byte", m_sh, e[7:0]);
      end
    end
  end

  always @(negedge clk) if (rst_n) begin
    logic [7:0] e;
    int d;
    if (rx_valid) begin
      rx_seen++;
      if (exp_rx.size() == 0) chk(0, "R6 unexpected rx", rx_data, 0);
      else begin e = exp_rx.pop_front(); chk(rx_data == e, "R6 rx byte", rx_data, e); end
    end
    if (done) begin
      chk((&csn) && !busy, "R3 release with done", {busy, csn}, 8'h3F);
      if (exp_done.size() == 0) chk(0, "R3 unexpected done", act_dev, 0);
      else begin d = exp_done.pop_front(); chk(int'(act_dev) == d, "R3 done device", act_dev, d); end
    end
    if (tx_ready) txr_cnt++;
    if (sclk) hi_run++;
    else if (hi_run != 0) begin
      if (hi_run != HALF) bad_phase++;
      hi_run = 0;
    end
  end

  task automatic expect_xfer(input int dev, input int len, input bit from_irq);
    int n;
    n = from_irq ? IRQ_RD : eff_len(dev, len);
    for (int i = 0; i < n; i++) begin
      exp_mosi.push_back({4'(dev), from_irq ? 8'h00 : txb(dev, i)});
      if (dev >= OPT_BASE) exp_rx.push_back(pat(dev, i));
    end
    exp_done.push_back(dev);
  endtask

  task automatic do_cmd(input int dev, input int len, input int stall);
    int n, start, r0;
    n = eff_len(dev, len);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_dev = 3'(dev); cmd_len = 5'(len);
    @(negedge clk);
    cmd_valid = 1'b0;
    start = byte_cnt;
    for (int i = 0; i < n; i++) begin
      while (!tx_ready) @(negedge clk);
      if (stall > 0) begin
        r0 = rises;
        repeat (stall) @(negedge clk);
        chk(rises == r0 && !sclk && !csn[dev], "R10 paused while withheld", rises - r0, 0);
      end
      tx_valid = 1'b1; tx_data = txb(dev, i);
      @(negedge clk);
      tx_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    chk(byte_cnt - start == n, "R5 byte count", byte_cnt - start, n);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    while (busy || irq != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    int r0, b0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_dev = '0; cmd_len = '0;
    tx_valid = 1'b0; tx_data = '0; irq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(csn == 6'h3F, "R1 reset selects", csn, 6'h3F);
    chk(!sclk, "R2 reset clock low", sclk, 0);
    chk(!busy && cmd_ready, "R7 reset idle", {busy, cmd_ready}, 1);
    chk(!done && !rx_valid, "R3 reset no strobes", {done, rx_valid}, 0);

    // write-only device, no returned bytes
    b0 = rx_seen;
    expect_xfer(1, 4, 0); do_cmd(1, 4, 0); settle();
    chk(rx_seen == b0, "R6 write-only silent", rx_seen - b0, 0);

    expect_xfer(0, 25, 0); do_cmd(0, 25, 0); settle();   // R5 wide cut to 21
    expect_xfer(2, 9, 0);  do_cmd(2, 9, 0);  settle();   // R5 narrow cut to 5
    expect_xfer(3, 0, 0);  do_cmd(3, 0, 0);  settle();   // R5 zero becomes one

    // option target command with withheld bytes (R10, R6)
    b0 = rx_seen;
    expect_xfer(4, 4, 0); do_cmd(4, 4, 3); settle();
    chk(rx_seen - b0 == 4, "R6 option read-back count", rx_seen - b0, 4);

    // R8 lone interrupt read
    txr_cnt = 0; r0 = rises;
    expect_xfer(5, 0, 1);
    @(negedge clk); irq = 2'b10;
    while (csn[5]) @(negedge clk);
    irq = 2'b00;
    settle();
    chk(txr_cnt == 0, "R8 no byte requests", txr_cnt, 0);
    chk(rises - r0 == 8 * IRQ_RD, "R2 edges per irq read", rises - r0, 8 * IRQ_RD);

    // R9 two interrupts raised while a command runs
    expect_xfer(2, 3, 0); expect_xfer(4, 0, 1); expect_xfer(5, 0, 1);
    fork
      do_cmd(2, 3, 0);
      begin
        while (!busy) @(negedge clk);
        irq = 2'b11;
        while (csn[4]) @(negedge clk);
        chk(csn[5], "R9 lower option first", csn[5], 1);
        irq[0] = 1'b0;
        while (csn[5]) @(negedge clk);
        irq[1] = 1'b0;
      end
    join
    settle();

    // R9 interrupt beats a waiting command
    expect_xfer(4, 0, 1); expect_xfer(1, 2, 0);
    @(negedge clk); irq = 2'b01;
    fork
      do_cmd(1, 2, 0);
      begin
        while (csn[4]) @(negedge clk);
        irq = 2'b00;
      end
    join
    settle();

    chk(exp_mosi.size() == 0, "R4 all bytes seen", exp_mosi.size(), 0);
    chk(exp_rx.size() == 0, "R6 all rx seen", exp_rx.size(), 0);
    chk(exp_done.size() == 0, "R3 all done seen", exp_done.size(), 0);
    chk(bad_phase == 0, "R4 high phase width", bad_phase, 0);
    chk(rises == 8 * byte_cnt, "R2 edges only for data", rises, 8 * byte_cnt);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule